// File: doc/BRIEF.md
# Stopwatch with Best-Time Memory

This block is a stopwatch built from a small control state machine and a datapath. A four-digit BCD timer counts elapsed ticks. A second four-digit BCD register keeps the shortest time recorded so far. The timer advances by one on each clock in which the tick enable is high. A clock prescaler outside the block sets the tick rate.

The user starts, stops and restarts timing with the control inputs. The user can also ask the block to compare the stopped time against the stored best. The stored value is replaced only when the new time is strictly smaller. After a compare, the block shows the stored best. A clear request reseeds the best value with 9999, from any state.

The output is a 29-bit vector for a four-digit seven-segment display with a fixed decimal point between the two upper and the two lower digits. It shows either the live timer or the stored best.

Top module: `best_lap_timer`

## Requirements
- R1: While `rst_n` is low, the timer reads 0000, the best value reads 9999, and the display shows the timer (0000).
- R2: From the idle seed state, a `start_i` pulse leads to a cycle that forces the timer to 0000. Counting begins on the cycle after that.
- R3: While counting, the timer advances by one BCD step on each clock edge at which `tick_i` is high and holds otherwise. Each digit rolls from 9 to 0 with a carry into the next digit.
- R4: The timer wraps from 9999 to 0000 on an enabled tick.
- R5: `stop_i` while counting freezes the timer, and the display keeps showing the timer.
- R6: `css_i` in the stopped state starts a compare. If timer < best, the best register takes the timer value, and the display then shows the best register.
- R7: If timer >= best at the compare (equal included), the best register is unchanged, and the display shows the best register.
- R8: `start_i` in the stopped state or in the best-showing state starts a new run from 0000. In the stopped state, `start_i` takes priority over `css_i`.
- R9: `clear_i` has priority over every other input in every state. It returns the block to the seed state, which reloads the best register with 9999.
- R10: `disp_o` is laid out as follows:
  - [28:22] is the thousands digit, [21:15] the hundreds, [14] the decimal point (always 1), [13:7] the tens and [6:0] the ones.
  - Within a digit, bit 6 is segment a and bit 0 is segment g. Segments are active high.
  - The digits 0 to 9 encode as 7E, 30, 6D, 79, 33, 5B, 5F, 70, 7F, 7B (hex).
- R11: While counting, `start_i` and `css_i` have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a new timing run |
| stop_i | input | 1 | Stop the running timer |
| css_i | input | 1 | Compare with the best time, store if smaller, show the best |
| clear_i | input | 1 | Reseed the best time with 9999 |
| tick_i | input | 1 | Count enable for the timer |
| disp_o | output | 29 | Segment vector for four digits and the decimal point |

## Verification
The bench drives compares in which the timer is below, equal to and above the stored best. A comparator that used `<=` would wrongly store on equality, and an inverted comparator would keep the worse time. A 9999-tick run checks the digit-carry chain at every boundary and the wrap to 0000. A run with a gappy tick checks that counting holds when the enable is low. Clear requests are issued while counting and while showing the best, and are followed by runs longer than the old best. A design that failed to reseed would then refuse the store. Simultaneous start and compare requests in the stopped state expose a wrong priority order.

// File: rtl/best_lap_pkg.sv
package best_lap_pkg;

  typedef enum logic [2:0] {
    PH_SEED, PH_ZERO, PH_RUN, PH_HALT, PH_CMP, PH_SAVE, PH_SHOW
  } phase_e;

  typedef struct packed {
    logic clr_tm;        // force timer to zero
    logic cnt_en;        // timer may advance
    logic best_we;       // best register write enable
    logic best_from_tm;  // 1: load timer, 0: load all-nines seed
    logic show_best;     // 1: display best, 0: display timer
    logic cmp_phase;     // compare decision cycle
  } ctl_t;

  // one BCD digit plus carry-in -> {carry-out, next digit}
  function automatic logic [4:0] digit_inc(input logic [3:0] d, input logic cin);
    if (!cin)          return {1'b0, d};
    else if (d >= 4'd9) return {1'b1, 4'd0};
    else               return {1'b0, d + 4'd1};
  endfunction

  // bit 6 = segment a ... bit 0 = segment g, active high
  function automatic logic [6:0] seg7(input logic [3:0] d);
    case (d)
      4'd0:    return 7'h7E;
      4'd1:    return 7'h30;
      4'd2:    return 7'h6D;
      4'd3:    return 7'h79;
      4'd4:    return 7'h33;
      4'd5:    return 7'h5B;
      4'd6:    return 7'h5F;
      4'd7:    return 7'h70;
      4'd8:    return 7'h7F;
      4'd9:    return 7'h7B;
      default: return 7'h00;
    endcase
  endfunction

endpackage

// File: rtl/bcd_counter.sv
module bcd_counter
  import best_lap_pkg::*;
#(
  parameter int DIGITS = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic                  en,
  output logic [4*DIGITS-1:0]   q
);
  localparam int W = 4 * DIGITS;

  logic [DIGITS:0] carry;
  logic [W-1:0]    nxt;

  assign carry[0] = en;

  generate
    for (genvar i = 0; i < DIGITS; i++) begin : g_dig
      assign {carry[i+1], nxt[4*i +: 4]} = digit_inc(q[4*i +: 4], carry[i]);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (clr) q <= '0;
    else          q <= nxt;
  end

  logic unused_top_carry;
  assign unused_top_carry = carry[DIGITS];
endmodule

// File: rtl/seg_display.sv
module seg_display
  import best_lap_pkg::*;
#(
  parameter int DIGITS = 4
) (
  input  logic [4*DIGITS-1:0] val,
  output logic [7*DIGITS:0]   vec
);
  localparam int DP_AT = DIGITS / 2;  // digits below the decimal point

  generate
    for (genvar i = 0; i < DIGITS; i++) begin : g_seg
      if (i < DP_AT) begin : g_lo
        assign vec[7*i +: 7] = seg7(val[4*i +: 4]);
      end else begin : g_hi
        assign vec[7*i + 1 +: 7] = seg7(val[4*i +: 4]);
      end
    end
  endgenerate

  assign vec[7*DP_AT] = 1'b1;
endmodule

// File: rtl/best_lap_ctrl.sv
module best_lap_ctrl
  import best_lap_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic stop,
  input  logic css,
  input  logic clear,
  input  logic lt,
  output ctl_t ctl
);
  phase_e ph_q, ph_d;

  always_comb begin
    ph_d = ph_q;
    unique case (ph_q)
      PH_SEED: if (start) ph_d = PH_ZERO;
      PH_ZERO: ph_d = PH_RUN;
      PH_RUN:  if (stop) ph_d = PH_HALT;
      PH_HALT: if (start) ph_d = PH_ZERO;
               else if (css) ph_d = PH_CMP;
      PH_CMP:  ph_d = lt ? PH_SAVE : PH_SHOW;
      PH_SAVE: ph_d = PH_SHOW;
      PH_SHOW: if (start) ph_d = PH_ZERO;
      default: ph_d = PH_SEED;
    endcase
    if (clear) ph_d = PH_SEED;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_SEED;
    else        ph_q <= ph_d;
  end

  always_comb begin
    ctl = '0;
    unique case (ph_q)
      PH_SEED: ctl.best_we = 1'b1;
      PH_ZERO: ctl.clr_tm  = 1'b1;
      PH_RUN:  ctl.cnt_en  = 1'b1;
      PH_CMP:  ctl.cmp_phase = 1'b1;
      PH_SAVE: begin
        ctl.best_we      = 1'b1;
        ctl.best_from_tm = 1'b1;
      end
      PH_SHOW: ctl.show_best = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/best_lap_timer.sv
module best_lap_timer
  import best_lap_pkg::*;
#(
  parameter int DIGITS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic                stop_i,
  input  logic                css_i,
  input  logic                clear_i,
  input  logic                tick_i,
  output logic [7*DIGITS:0]   disp_o
);
  localparam int          W    = 4 * DIGITS;
  localparam logic [W-1:0] SEED = {DIGITS{4'h9}};

  ctl_t       ctl;
  logic [W-1:0] tm_q, best_q, shown;

  // named events for the checker
  logic ev_clr_tm, ev_count, ev_best_we, ev_best_from_tm, ev_show_best, ev_cmp, ev_lt;
  assign ev_clr_tm       = ctl.clr_tm;
  assign ev_count        = ctl.cnt_en;
  assign ev_best_we      = ctl.best_we;
  assign ev_best_from_tm = ctl.best_from_tm;
  assign ev_show_best    = ctl.show_best;
  assign ev_cmp          = ctl.cmp_phase;

  // valid BCD orders like unsigned binary
  assign ev_lt = (tm_q < best_q);

  best_lap_ctrl u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start_i),
    .stop  (stop_i),
    .css   (css_i),
    .clear (clear_i),
    .lt    (ev_lt),
    .ctl   (ctl)
  );

  bcd_counter #(.DIGITS(DIGITS)) u_tm (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (ctl.clr_tm),
    .en    (ctl.cnt_en & tick_i),
    .q     (tm_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           best_q <= SEED;
    else if (ctl.best_we) best_q <= ctl.best_from_tm ? tm_q : SEED;
  end

  assign shown = ctl.show_best ? best_q : tm_q;

  seg_display #(.DIGITS(DIGITS)) u_disp (
    .val (shown),
    .vec (disp_o)
  );
endmodule

// File: rtl/best_lap_timer_chk.sv
module best_lap_timer_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         stop_i,
  input logic         clear_i,
  input logic         tick_i,
  input logic [W-1:0] tm,
  input logic [W-1:0] best,
  input logic         clr_tm,
  input logic         count,
  input logic         best_we,
  input logic         best_from_tm,
  input logic         show_best,
  input logic         cmp,
  input logic         lt
);
  localparam logic [W-1:0] NINES = {(W/4){4'h9}};

  // R2
  zero_after_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_tm |=> (tm == '0));

  // R3
  hold_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count && !tick_i) |=> $stable(tm));

  // R5
  stop_freezes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count && stop_i && !clear_i) |=> (!count && !show_best));

  // R6
  store_takes_timer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (best_we && best_from_tm) |=> (best == $past(tm)));

  // R7
  no_store_when_not_less_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp && !lt && !clear_i) |=> (!best_we && show_best));

  // R9
  clear_goes_to_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (best_we && !best_from_tm));

  // R9
  seed_loads_nines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (best_we && !best_from_tm) |=> (best == NINES));
endmodule

bind best_lap_timer best_lap_timer_chk #(.W(4*DIGITS)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .stop_i       (stop_i),
  .clear_i      (clear_i),
  .tick_i       (tick_i),
  .tm           (tm_q),
  .best         (best_q),
  .clr_tm       (ev_clr_tm),
  .count        (ev_count),
  .best_we      (ev_best_we),
  .best_from_tm (ev_best_from_tm),
  .show_best    (ev_show_best),
  .cmp          (ev_cmp),
  .lt           (ev_lt)
);

// File: tb/best_lap_timer_tb.sv
module best_lap_timer_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 0, stop_i = 0, css_i = 0, clear_i = 0, tick_i = 0;
  logic [28:0] disp_o;

  always #10 clk = ~clk;  // 50 MHz

  best_lap_timer dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .css_i(css_i), .clear_i(clear_i), .tick_i(tick_i), .disp_o(disp_o)
  );

  int vectors = 0;
  int errors  = 0;
  string cur_req = "R1";

  // behavioural model: mode 1 idle/seed, 2 zeroing, 3 running,
  // 4 stopped, 5 deciding, 6 storing, 7 showing best
  int m_mode = 1;
  int m_tm   = 0;
  int m_best = 9999;

  function automatic logic [6:0] seg_of(int d);
    logic [6:0] s;
    s[6] = !(d == 1 || d == 4);
    s[5] = !(d == 5 || d == 6);
    s[4] = (d != 2);
    s[3] = !(d == 1 || d == 4 || d == 7);
    s[2] = (d == 0 || d == 2 || d == 6 || d == 8);
    s[1] = !(d == 1 || d == 2 || d == 3 || d == 7);
    s[0] = !(d == 0 || d == 1 || d == 7);
    return s;
  endfunction

  function automatic logic [28:0] expect_vec(int v);
    return {seg_of((v / 1000) % 10), seg_of((v / 100) % 10), 1'b1,
            seg_of((v / 10) % 10), seg_of(v % 10)};
  endfunction

  task automatic compare();
    logic [28:0] e;
    e = expect_vec(m_mode == 7 ? m_best : m_tm);
    vectors++;
    if (disp_o !== e) begin
      errors++;
      $display("FAIL %s: disp_o=%h expected %h (timer %0d best %0d)",
               cur_req, disp_o, e, m_tm, m_best);
    end
  endtask

  task automatic model_edge(bit s, bit p, bit c, bit r, bit t);
    int nxt;
    nxt = m_mode;
    case (m_mode)
      1: begin m_best = 9999; if (s) nxt = 2; end
      2: begin m_tm = 0; nxt = 3; end
      3: begin if (t) m_tm = (m_tm + 1) % 10000; if (p) nxt = 4; end
      4: begin if (s) nxt = 2; else if (c) nxt = 5; end
      5: nxt = (m_tm < m_best) ? 6 : 7;
      6: begin m_best = m_tm; nxt = 7; end
      7: if (s) nxt = 2;
      default: nxt = 1;
    endcase
    if (r) nxt = 1;
    m_mode = nxt;
  endtask

  // called at a negative edge
  task automatic step(bit s, bit p, bit c, bit r, bit t);
    start_i = s; stop_i = p; css_i = c; clear_i = r; tick_i = t;
    @(posedge clk);
    model_edge(s, p, c, r, t);
    @(negedge clk);
    compare();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 1);
  endtask

  task automatic timed_run(int n);
    step(1, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    ticks(n);
    step(0, 1, 0, 0, 0);
  endtask

  task automatic do_compare();
    step(0, 0, 1, 0, 0);
    idle(3);
  endtask

  initial begin
    // R1: state held in reset
    repeat (3) @(negedge clk);
    compare();
    rst_n = 1'b1;
    @(negedge clk);
    compare();

    // R10: seed state shows 0000 in the given layout
    cur_req = "R10";
    idle(4);

    // R2: start, zeroing cycle, then counting
    cur_req = "R2";
    step(1, 0, 0, 0, 1);
    step(0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 1);

    // R3: gappy tick pattern with carries
    cur_req = "R3";
    for (int i = 0; i < 1500; i++) step(0, 0, 0, 0, (i % 3) != 1);

    // R11: start/css ignored while counting
    cur_req = "R11";
    for (int i = 0; i < 6; i++) step(1, 0, 1, 0, 1);

    // R5: stop freezes the timer
    cur_req = "R5";
    step(0, 1, 0, 0, 1);
    ticks(20);

    // R6: first compare stores (below 9999)
    cur_req = "R6";
    do_compare();

    // R6: shorter run stores again
    cur_req = "R8";
    timed_run(0);
    cur_req = "R6";
    step(0, 0, 0, 0, 0);
    cur_req = "R8";
    timed_run(357);
    cur_req = "R6";
    do_compare();

    // R7: longer run does not store
    cur_req = "R7";
    timed_run(800);
    do_compare();
    // R7: equal run does not store
    timed_run(357);
    do_compare();

    // R8: start beats css in the stopped state
    cur_req = "R8";
    timed_run(40);
    step(1, 0, 1, 0, 0);
    idle(2);
    ticks(5);
    step(0, 1, 0, 0, 0);
    do_compare();

    // R9: clear while showing best, then longer run must still store
    cur_req = "R9";
    step(0, 0, 0, 1, 0);
    idle(3);
    timed_run(2000);
    do_compare();
    // R9: clear while counting
    timed_run(10);
    step(1, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1);
    ticks(30);
    step(0, 1, 1, 1, 1);
    idle(2);
    timed_run(2500);
    do_compare();

    // R4: full count to 9999, compare against 9999 seed (equal), then wrap
    cur_req = "R4";
    step(0, 0, 0, 1, 0);
    timed_run(9999);
    do_compare();
    step(1, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    ticks(10002);
    step(0, 1, 0, 0, 0);
    idle(3);

    start_i = 0; stop_i = 0; css_i = 0; clear_i = 0; tick_i = 0;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule